// File: doc/BRIEF.md
# Eight-Channel Programmable Pulse Generator

This block produces eight free-running periodic pulse trains from a single system clock. Each channel has its own period length and high time, both counted in clock cycles. One configuration bus is shared by all channels. It carries a period value, a high-time value, a channel selector and a load strobe. When the strobe is high, the addressed channel captures the bus values. Every other channel keeps its settings and keeps running.

Captured settings wait in a staging register. They become active when the channel's counter next returns to zero, so a period that is already running always finishes with the settings it started with. A channel that has never been configured, or whose period is zero, counts as idle. An idle channel adopts new settings on the same edge that captures them.

Top module: `multi_pulse_gen`

## Requirements
- R1: A synchronous active-high reset clears every channel's staged and active period and width, and every counter. On the edge after reset, all eight outputs are low.
- R2: When `cfg_load` is high and `cfg_sel` holds a value from 0 to 7, only that channel captures `cfg_period` and `cfg_width` on the clock edge.
- R3: Selector values 8 to 63 and a low `cfg_load` update no channel, and no output changes because of them.
- R4: A channel with an active period of P (P ≥ 1) repeats its waveform every P clock cycles.
- R5: Within each period, the output is high while the channel count is 0 to W−1 and low while it is W to P−1. The first cycle after a wrap has count 0.
- R6: Settings captured in the middle of a period take effect only at the next wrap. The current period completes with the old period and width.
- R7: A capture on the same edge as a wrap is applied at that wrap. The new period starts with count 0.
- R8: An active period of 0 holds the output low, whatever the width.
- R9: An active width of 0 holds the output low, whatever the period.
- R10: An active width at least as large as a nonzero active period holds the output constantly high. This includes a period of 1 with a width of 1.
- R11: Loading one channel does not stall, restart or alter the count of any other channel.
- R12: An idle channel (active period 0) adopts newly captured settings on the capture edge. Its count is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Strobe that qualifies the selector |
| cfg_sel | input | 6 | Channel address; values 0 to 7 are valid |
| cfg_period | input | 16 | Period in clock cycles |
| cfg_width | input | 10 | High time in clock cycles |
| pulse_out | output | 8 | One pulse output per channel, bit i for channel i |

## Verification
Two channel events can land on the same edge: a capture from the bus and the period wrap. These are the cases where the forwarding path and the staging register could disagree. The bench keeps a cycle model of every channel. It waits until the model shows a channel one count before its wrap, then issues the load on that exact edge. It expects the new period to begin at count 0 straight away (R7). A mid-period load, which must wait one full period (R6), serves as the contrast case. All eight outputs are compared every cycle, so any disturbance to a neighbouring channel is also caught (R11).

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  // Channel count at which the counter must return to zero.
  // A zero period means the channel is idle and wraps on every edge.
  function automatic logic at_wrap(input int unsigned cnt, input int unsigned per);
    if (per == 0) return 1'b1;
    return (cnt == per - 1);
  endfunction

  // Output level for a given count and active settings.
  function automatic logic pulse_level(input int unsigned cnt, input int unsigned per,
                                       input int unsigned wid);
    if (per == 0) return 1'b0;
    return (cnt < wid);
  endfunction

endpackage

// File: rtl/pgen_sel_decode.sv
module pgen_sel_decode #(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CH-1:0] ld_en
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign ld_en[i] = load && (sel == SEL_W'(i));
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_en)); // R2
  AST_OUT_OF_RANGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!load || (32'(sel) >= NUM_CH)) |-> (ld_en == '0)); // R3

endmodule

// File: rtl/pgen_channel.sv
module pgen_channel #(
  parameter int PER_W = 16,
  parameter int WID_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [PER_W-1:0] per_in,
  input  logic [WID_W-1:0] wid_in,
  output logic             pulse
);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] act_per_q, stg_per_q, per_src;
  logic [WID_W-1:0] act_wid_q, stg_wid_q, wid_src;
  logic             wrap;

  // Named event: counter returns to zero on the coming edge.
  assign wrap    = pgen_pkg::at_wrap(32'(cnt_q), 32'(act_per_q));
  // A capture on the wrap edge is forwarded straight into the active set.
  assign per_src = ld_en ? per_in : stg_per_q;
  assign wid_src = ld_en ? wid_in : stg_wid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      act_per_q <= '0;
      act_wid_q <= '0;
      stg_per_q <= '0;
      stg_wid_q <= '0;
    end else begin
      if (ld_en) begin
        stg_per_q <= per_in;
        stg_wid_q <= wid_in;
      end
      if (wrap) begin
        cnt_q     <= '0;
        act_per_q <= per_src;
        act_wid_q <= wid_src;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pulse = pgen_pkg::pulse_level(32'(cnt_q), 32'(act_per_q), 32'(act_wid_q));

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (act_per_q != '0) |-> (cnt_q < act_per_q)); // R4
  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0)); // R5
  AST_MIDPERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(act_per_q) && $stable(act_wid_q))); // R6
  AST_WRAP_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (wrap && ld_en) |=> ((act_per_q == $past(per_in)) && (act_wid_q == $past(wid_in)))); // R7
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (act_per_q == '0) |-> !pulse); // R8
  AST_NO_WIDTH_LOW: assert property (@(posedge clk) disable iff (rst)
    (act_wid_q == '0) |-> !pulse); // R9
  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
    ((act_per_q != '0) && (32'(act_wid_q) >= 32'(act_per_q))) |-> pulse); // R10
  AST_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> (cnt_q == PER_W'($past(cnt_q) + 1'b1))); // R11

endmodule

// File: rtl/multi_pulse_gen.sv
module multi_pulse_gen #(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 6,
  parameter int PER_W  = 16,
  parameter int WID_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [WID_W-1:0]  cfg_width,
  output logic [NUM_CH-1:0] pulse_out
);

  localparam int ADDR_SPACE = 1 << SEL_W;

  logic [NUM_CH-1:0] ld_en;

  initial begin
    if (NUM_CH > ADDR_SPACE) $error("selector too narrow for channel count");
    if (PER_W > 32 || WID_W > 32) $error("counter widths limited to 32 bits");
  end

  pgen_sel_decode #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dec (
    .clk   (clk),
    .rst   (rst),
    .load  (cfg_load),
    .sel   (cfg_sel),
    .ld_en (ld_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pgen_channel #(.PER_W(PER_W), .WID_W(WID_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .ld_en  (ld_en[c]),
      .per_in (cfg_period),
      .wid_in (cfg_width),
      .pulse  (pulse_out[c])
    );
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pulse_out == '0)); // R1

endmodule

// File: tb/test_multi_pulse_gen.sv
`timescale 1ns/1ps
module test_multi_pulse_gen;
  localparam int NCH = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [5:0] cfg_sel = '0;
  logic [15:0] cfg_period = '0;
  logic [9:0] cfg_width = '0;
  logic [7:0] pulse_out;

  always #2.5 clk = ~clk;

  multi_pulse_gen i_multi_pulse_gen (
    .clk        (clk),
    .rst        (rst),
    .cfg_load   (cfg_load),
    .cfg_sel    (cfg_sel),
    .cfg_period (cfg_period),
    .cfg_width  (cfg_width),
    .pulse_out  (pulse_out)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  // Reference model: phase, active and staged settings per channel.
  int m_ph[NCH];
  int m_cp[NCH];
  int m_cw[NCH];
  int m_np[NCH];
  int m_nw[NCH];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pulse_out=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs
  // that follow the next rising edge.
  task automatic step(input bit r, input bit ld, input int s, input int p, input int w);
    item_t it;
    int    np, nw;
    bit    hit, ends;
    @(negedge clk);
    rst        = r;
    cfg_load   = ld;
    cfg_sel    = 6'(s);
    cfg_period = 16'(p);
    cfg_width  = 10'(w);
    for (int c = 0; c < NCH; c++) begin
      if (r) begin
        m_ph[c] = 0; m_cp[c] = 0; m_cw[c] = 0; m_np[c] = 0; m_nw[c] = 0;
      end else begin
        hit  = ld && (s == c);
        np   = hit ? p : m_np[c];
        nw   = hit ? w : m_nw[c];
        ends = (m_cp[c] == 0) || (m_ph[c] + 1 >= m_cp[c]);
        if (ends) begin
          m_ph[c] = 0;
          m_cp[c] = np;
          m_cw[c] = nw;
        end else begin
          m_ph[c] = m_ph[c] + 1;
        end
        m_np[c] = np;
        m_nw[c] = nw;
      end
      it.exp[c] = (m_cp[c] > 0) && (m_ph[c] < m_cw[c]);
    end
    it.tag = cur_tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  // Monitor: pops one expected item per rising edge, away from the edge.
  initial begin
    item_t got;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        got = sb_q.pop_front();
        check(got.tag, pulse_out, got.exp);
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: pulse_out=%b expected=run complete", pulse_out);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cur_tag = "R1";
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    @(posedge clk); #1;
    check("R1 reset state", pulse_out, 8'h00);

    // Idle channel 0 adopts at once; period 5, width 2.
    cur_tag = "R12";
    step(0, 1, 0, 5, 2);
    cur_tag = "R4 R5";
    idle(12);

    // Full duty, zero width, zero period on channels 1..3.
    cur_tag = "R10";
    step(0, 1, 1, 4, 4);
    cur_tag = "R9";
    step(0, 1, 2, 3, 0);
    cur_tag = "R8";
    step(0, 1, 3, 0, 3);
    idle(8);

    // Out-of-range selector and low strobe must change nothing.
    cur_tag = "R3";
    step(0, 1, 9, 2, 1);
    step(0, 1, 63, 2, 1);
    step(0, 0, 4, 2, 1);
    idle(4);
    @(posedge clk); #1;
    check("R3 channel 4 untouched", {7'b0, pulse_out[4]}, 8'h00);

    // Mid-period reprogram of channel 0: old period must finish first.
    cur_tag = "R6";
    while (m_ph[0] != 1) idle(1);
    step(0, 1, 0, 3, 1);
    cur_tag = "R11";
    idle(10);

    // Load that coincides with the wrap of channel 5.
    cur_tag = "R12";
    step(0, 1, 5, 4, 1);
    idle(3);
    while (!(m_cp[5] != 0 && m_ph[5] == m_cp[5] - 1)) idle(1);
    cur_tag = "R7";
    step(0, 1, 5, 6, 3);
    idle(14);

    // Boundary: period 1 width 1 high always; period 2 width 1 toggles.
    cur_tag = "R10";
    step(0, 1, 6, 1, 1);
    cur_tag = "R4";
    step(0, 1, 7, 2, 1);
    idle(8);

    // Reset in the middle of activity.
    cur_tag = "R1";
    step(1, 0, 0, 0, 0);
    idle(3);

    idle(2);
    @(posedge clk); #2;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule